// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block places a 16x16 pointer image over a stream of video pixels. Each pixel arrives with its raster column and row. If the cursor is enabled and the pixel lies inside the square whose top-left corner is the cursor position, the block reads one bit from each of two image planes and picks one of four results: the background colour, the foreground colour, the pixel unchanged, or the pixel with every bit inverted. Every other pixel goes through unchanged. The result comes out one clock later.

The image planes and the control values are loaded through a byte-addressed write port. Half of the address space is a 256-byte cursor image laid out as sixteen 16-byte rows. The other half holds a small set of registers: enable, position and the two colours. Position writes are held in a shadow copy. They reach the overlay only at the next pixel marked as the start of a frame, so the cursor never jumps partway through a frame.

Top module: `cursor_overlay`

## Requirements
- R1: Reset clears `pix_out` and `pix_out_valid` to 0, disables the cursor, sets the foreground colour to 0xFFFFFF, the background colour to 0x000000, and clears both planes and all position values to 0.
- R2: `pix_out_valid` is `pix_in_valid` delayed by one clock. While `pix_out_valid` is 0, `pix_out` is 0.
- R3: A valid pixel that is outside the cursor square, or that arrives while the cursor is disabled, appears unchanged on `pix_out` one clock later.
- R4: A pixel is inside the square when cx <= x <= cx+15 and cy <= y <= cy+15. Column c = x-cx and row r = y-cy select the image bits.
- R5: Image byte address r*16+k (wr_addr[8]=0) writes row r. k=0 holds the select plane for columns 0-7 and k=1 holds it for columns 8-15. k=8 and k=9 do the same for the opacity plane. The most significant bit of a byte is the leftmost column. Writes to any other k have no effect.
- R6: Inside the square, with opacity bit o and select bit s: o=0,s=0 passes the pixel; o=0,s=1 outputs its bitwise inverse; o=1,s=0 outputs the background colour; o=1,s=1 outputs the foreground colour.
- R7: Register writes (wr_addr[8]=1) decode wr_addr[2:0]: 0 = enable (wr_data[0]), 1 = cursor x, 2 = cursor y, 3 = foreground, 4 = background. Indices 5-7 are ignored. Enable and colour writes act on the next pixel.
- R8: Cursor x and y writes are held back. They take effect on the next valid pixel with `pix_frame_start` set, and that pixel already uses them.
- R9: A write in the same clock as a pixel affects only later pixels.
- R10: The square does not wrap at the top of the coordinate range. With cx = 4090, only columns 4090-4095 are covered and columns 0-9 are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Bit 8 selects registers (1) or image bytes (0) |
| wr_data | input | 24 | Write data; image writes use bits 7:0 |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_frame_start | input | 1 | Marks the first pixel of a frame |
| pix_x | input | 12 | Raster column of the input pixel |
| pix_y | input | 12 | Raster row of the input pixel |
| pix_in | input | 24 | Input pixel colour |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 24 | Output pixel colour |

## Verification
A corrupted image bit changes exactly one pixel inside the square, on the cycle after that pixel enters, to a different one of the four outcomes. A bad enable or colour register shows up on the first pixel inside the square after the write. A fault in the shadowed position moves the whole square. That error is visible from the frame-start pixel, or from the first in-window pixel after it. The bench sweeps areas that cover the square and its edges, with idle gaps between pixels. Its reference model predicts every output cycle, so any of these faults is caught within one clock of the affected pixel.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    // Cursor geometry: square side and index width
    localparam int CUR_DIM   = 16;
    localparam int CUR_IDX_W = $clog2(CUR_DIM);
    // Image memory: one row of CUR_DIM bytes per cursor line
    localparam int MEM_BYTES = CUR_DIM * CUR_DIM;
    localparam int MEM_AW    = $clog2(MEM_BYTES);
    localparam int ADDR_W    = MEM_AW + 1;
    // Byte offsets inside one image row
    localparam logic [CUR_IDX_W-1:0] OFF_SEL_HI = 4'd0;
    localparam logic [CUR_IDX_W-1:0] OFF_SEL_LO = 4'd1;
    localparam logic [CUR_IDX_W-1:0] OFF_OPQ_HI = 4'd8;
    localparam logic [CUR_IDX_W-1:0] OFF_OPQ_LO = 4'd9;
    // Register indices
    localparam int REG_SEL_W = 3;
    localparam logic [REG_SEL_W-1:0] REG_ENABLE = 3'd0;
    localparam logic [REG_SEL_W-1:0] REG_POS_X  = 3'd1;
    localparam logic [REG_SEL_W-1:0] REG_POS_Y  = 3'd2;
    localparam logic [REG_SEL_W-1:0] REG_FG     = 3'd3;
    localparam logic [REG_SEL_W-1:0] REG_BG     = 3'd4;

    // Pixel outcome, encoded as {opacity, select}
    typedef enum logic [1:0] {
        ACT_PASS   = 2'b00,
        ACT_INVERT = 2'b01,
        ACT_BG     = 2'b10,
        ACT_FG     = 2'b11
    } cursor_act_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int XW = 12,
    parameter int CW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_SEL_W-1:0] wr_sel,
    input  logic [CW-1:0]        wr_data,
    input  logic                 frame_load,
    output logic                 cur_en,
    output logic [CW-1:0]        fg_col,
    output logic [CW-1:0]        bg_col,
    output logic [XW-1:0]        pend_x,
    output logic [XW-1:0]        pend_y,
    output logic [XW-1:0]        act_x,
    output logic [XW-1:0]        act_y
);
    typedef struct packed {
        logic          en;
        logic [CW-1:0] fg;
        logic [CW-1:0] bg;
        logic [XW-1:0] pend_x;
        logic [XW-1:0] pend_y;
        logic [XW-1:0] act_x;
        logic [XW-1:0] act_y;
    } regs_t;

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Shadow position moves to the live copy at frame start
        if (frame_load) begin
            state_d.act_x = state_q.pend_x;
            state_d.act_y = state_q.pend_y;
        end
        if (wr_en) begin
            case (wr_sel)
                REG_ENABLE: state_d.en     = wr_data[0];
                REG_POS_X:  state_d.pend_x = wr_data[XW-1:0];
                REG_POS_Y:  state_d.pend_y = wr_data[XW-1:0];
                REG_FG:     state_d.fg     = wr_data;
                REG_BG:     state_d.bg     = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.en     <= 1'b0;
            state_q.fg     <= '1;
            state_q.bg     <= '0;
            state_q.pend_x <= '0;
            state_q.pend_y <= '0;
            state_q.act_x  <= '0;
            state_q.act_y  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_en = state_q.en;
    assign fg_col = state_q.fg;
    assign bg_col = state_q.bg;
    assign pend_x = state_q.pend_x;
    assign pend_y = state_q.pend_y;
    assign act_x  = state_q.act_x;
    assign act_y  = state_q.act_y;
endmodule

// File: rtl/cursor_planes.sv
module cursor_planes
    import cursor_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [MEM_AW-1:0]    wr_addr,
    input  logic [7:0]           wr_byte,
    input  logic [CUR_IDX_W-1:0] rd_row,
    input  logic [CUR_IDX_W-1:0] rd_col,
    output logic                 sel_bit,
    output logic                 opq_bit
);
    logic [CUR_IDX_W-1:0] wr_row;
    logic [CUR_IDX_W-1:0] wr_off;
    logic [CUR_IDX_W-1:0] bit_idx;
    logic [CUR_DIM-1:0]   sel_rows [CUR_DIM];
    logic [CUR_DIM-1:0]   opq_rows [CUR_DIM];

    assign wr_row = wr_addr[MEM_AW-1:CUR_IDX_W];
    assign wr_off = wr_addr[CUR_IDX_W-1:0];

    for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
        logic [CUR_DIM-1:0] sel_d, sel_q;
        logic [CUR_DIM-1:0] opq_d, opq_q;

        always_comb begin
            sel_d = sel_q;
            opq_d = opq_q;
            if (wr_en && (wr_row == CUR_IDX_W'(r))) begin
                case (wr_off)
                    OFF_SEL_HI: sel_d[CUR_DIM-1:8] = wr_byte;
                    OFF_SEL_LO: sel_d[7:0]         = wr_byte;
                    OFF_OPQ_HI: opq_d[CUR_DIM-1:8] = wr_byte;
                    OFF_OPQ_LO: opq_d[7:0]         = wr_byte;
                    default:    ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q <= '0;
                opq_q <= '0;
            end else begin
                sel_q <= sel_d;
                opq_q <= opq_d;
            end
        end

        assign sel_rows[r] = sel_q;
        assign opq_rows[r] = opq_q;
    end

    // Leftmost column sits in the most significant bit
    assign bit_idx = CUR_IDX_W'(CUR_DIM - 1) - rd_col;
    assign sel_bit = sel_rows[rd_row][bit_idx];
    assign opq_bit = opq_rows[rd_row][bit_idx];
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import cursor_pkg::*;
#(
    parameter int XW = 12,
    parameter int CW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid,
    input  logic                 frame_load,
    input  logic [XW-1:0]        pix_x,
    input  logic [XW-1:0]        pix_y,
    input  logic [CW-1:0]        pix_in,
    input  logic                 cur_en,
    input  logic [XW-1:0]        pend_x,
    input  logic [XW-1:0]        pend_y,
    input  logic [XW-1:0]        act_x,
    input  logic [XW-1:0]        act_y,
    input  logic [CW-1:0]        fg_col,
    input  logic [CW-1:0]        bg_col,
    input  logic                 sel_bit,
    input  logic                 opq_bit,
    output logic [CUR_IDX_W-1:0] rd_row,
    output logic [CUR_IDX_W-1:0] rd_col,
    output logic                 out_valid,
    output logic [CW-1:0]        out_pix
);
    typedef struct packed {
        logic          valid;
        logic [CW-1:0] pix;
    } out_t;

    out_t        out_d, out_q;
    logic [XW-1:0] org_x, org_y;
    logic [XW:0] dx, dy;
    logic        in_x, in_y, hit;
    cursor_act_e act;

    always_comb begin
        // The frame-start pixel already sees the shadowed position
        org_x = frame_load ? pend_x : act_x;
        org_y = frame_load ? pend_y : act_y;
        dx    = {1'b0, pix_x} - {1'b0, org_x};
        dy    = {1'b0, pix_y} - {1'b0, org_y};
        in_x  = !dx[XW] && (dx[XW-1:0] < XW'(CUR_DIM));
        in_y  = !dy[XW] && (dy[XW-1:0] < XW'(CUR_DIM));
        hit   = cur_en && in_x && in_y;
        act   = cursor_act_e'({opq_bit, sel_bit});

        out_d = '0;
        if (pix_valid) begin
            out_d.valid = 1'b1;
            out_d.pix   = pix_in;
            if (hit) begin
                case (act)
                    ACT_PASS:   out_d.pix = pix_in;
                    ACT_INVERT: out_d.pix = ~pix_in;
                    ACT_BG:     out_d.pix = bg_col;
                    ACT_FG:     out_d.pix = fg_col;
                    default:    out_d.pix = pix_in;
                endcase
            end
        end
    end

    assign rd_col = dx[CUR_IDX_W-1:0];
    assign rd_row = dy[CUR_IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_pix   = out_q.pix;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int XW = 12,
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic              pix_in_valid,
    input  logic              pix_frame_start,
    input  logic [XW-1:0]     pix_x,
    input  logic [XW-1:0]     pix_y,
    input  logic [CW-1:0]     pix_in,
    output logic              pix_out_valid,
    output logic [CW-1:0]     pix_out
);
    logic                 reg_we, mem_we, frame_load;
    logic                 cur_en;
    logic [CW-1:0]        fg_col, bg_col;
    logic [XW-1:0]        pend_x, pend_y, act_x, act_y;
    logic [CUR_IDX_W-1:0] rd_row, rd_col;
    logic                 sel_bit, opq_bit;

    assign reg_we     = wr_en &&  wr_addr[ADDR_W-1];
    assign mem_we     = wr_en && !wr_addr[ADDR_W-1];
    assign frame_load = pix_in_valid && pix_frame_start;

    cursor_regs #(.XW(XW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_sel     (wr_addr[REG_SEL_W-1:0]),
        .wr_data    (wr_data),
        .frame_load (frame_load),
        .cur_en     (cur_en),
        .fg_col     (fg_col),
        .bg_col     (bg_col),
        .pend_x     (pend_x),
        .pend_y     (pend_y),
        .act_x      (act_x),
        .act_y      (act_y)
    );

    cursor_planes u_planes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_addr (wr_addr[MEM_AW-1:0]),
        .wr_byte (wr_data[7:0]),
        .rd_row  (rd_row),
        .rd_col  (rd_col),
        .sel_bit (sel_bit),
        .opq_bit (opq_bit)
    );

    cursor_mix #(.XW(XW), .CW(CW)) u_mix (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_in_valid),
        .frame_load (frame_load),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .pix_in     (pix_in),
        .cur_en     (cur_en),
        .pend_x     (pend_x),
        .pend_y     (pend_y),
        .act_x      (act_x),
        .act_y      (act_y),
        .fg_col     (fg_col),
        .bg_col     (bg_col),
        .sel_bit    (sel_bit),
        .opq_bit    (opq_bit),
        .rd_row     (rd_row),
        .rd_col     (rd_col),
        .out_valid  (pix_out_valid),
        .out_pix    (pix_out)
    );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int XW = 12,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_in_valid,
    input logic          pix_frame_start,
    input logic [CW-1:0] pix_in,
    input logic          pix_out_valid,
    input logic [CW-1:0] pix_out,
    input logic          cur_en,
    input logic [XW-1:0] act_x,
    input logic [XW-1:0] act_y
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_in_valid |=> pix_out_valid);

    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_in_valid |=> !pix_out_valid);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_out_valid |-> (pix_out == '0));

    // R3
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && !cur_en) |=> (pix_out == $past(pix_in)));

    // R8
    frame_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_in_valid && pix_frame_start) |=> ($stable(act_x) && $stable(act_y)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.XW(XW), .CW(CW)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .pix_in_valid    (pix_in_valid),
    .pix_frame_start (pix_frame_start),
    .pix_in          (pix_in),
    .pix_out_valid   (pix_out_valid),
    .pix_out         (pix_out),
    .cur_en          (cur_en),
    .act_x           (act_x),
    .act_y           (act_y)
);

// File: tb/cursor_overlay_tb_top.sv
`timescale 1ns/1ps
module cursor_overlay_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        pix_in_valid = 1'b0;
    logic        pix_frame_start = 1'b0;
    logic [11:0] pix_x = '0;
    logic [11:0] pix_y = '0;
    logic [23:0] pix_in = '0;
    logic        pix_out_valid;
    logic [23:0] pix_out;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    cursor_overlay dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_in_valid(pix_in_valid), .pix_frame_start(pix_frame_start),
        .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out)
    );

    // Behavioural reference model
    bit [15:0]   m_sel [16];
    bit [15:0]   m_opq [16];
    bit          m_en;
    logic [23:0] m_fg, m_bg;
    int          pend_x, pend_y, act_x, act_y;
    bit          armed = 0;
    bit          exp_v;
    logic [23:0] exp_d;
    string       exp_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_sel[i]) begin m_sel[i] = '0; m_opq[i] = '0; end
            m_en = 0; m_fg = 24'hFFFFFF; m_bg = 24'h000000;
            pend_x = 0; pend_y = 0; act_x = 0; act_y = 0;
            exp_v = 0; exp_d = '0; armed = 0;
        end else begin
            armed = 1;
            if (pix_in_valid) begin
                int ox, oy, c, r;
                ox = pix_frame_start ? pend_x : act_x;
                oy = pix_frame_start ? pend_y : act_y;
                c = int'(pix_x) - ox;
                r = int'(pix_y) - oy;
                exp_v = 1;
                if (m_en && c >= 0 && c < 16 && r >= 0 && r < 16) begin
                    bit s, o;
                    s = m_sel[r][15-c];
                    o = m_opq[r][15-c];
                    if (!o) exp_d = s ? ~pix_in : pix_in;
                    else    exp_d = s ? m_fg : m_bg;
                    exp_tag = "R6";
                end else begin
                    exp_d = pix_in;
                    exp_tag = "R3";
                end
                if (pix_frame_start) begin act_x = pend_x; act_y = pend_y; end
            end else begin
                exp_v = 0; exp_d = '0; exp_tag = "R2";
            end
            if (wr_en) begin
                if (wr_addr[8]) begin
                    case (wr_addr[2:0])
                        3'd0: m_en = wr_data[0];
                        3'd1: pend_x = int'(wr_data[11:0]);
                        3'd2: pend_y = int'(wr_data[11:0]);
                        3'd3: m_fg = wr_data;
                        3'd4: m_bg = wr_data;
                        default: ;
                    endcase
                end else begin
                    int rr;
                    rr = int'(wr_addr[7:4]);
                    case (wr_addr[3:0])
                        4'd0: m_sel[rr][15:8] = wr_data[7:0];
                        4'd1: m_sel[rr][7:0]  = wr_data[7:0];
                        4'd8: m_opq[rr][15:8] = wr_data[7:0];
                        4'd9: m_opq[rr][7:0]  = wr_data[7:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always @(negedge clk) begin
        if (armed && rst_n && !finished) begin
            checks++;
            if (pix_out_valid !== exp_v || pix_out !== exp_d) begin
                fails++;
                $display("FAIL %s/%s t=%0t got v=%0b d=%06h exp v=%0b d=%06h",
                         phase, exp_tag, $time, pix_out_valid, pix_out, exp_v, exp_d);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = a[8:0]; wr_data = d[23:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic area(input int x0, input int x1, input int y0, input int y1, input bit sof);
        bit first;
        int k;
        first = sof;
        k = 0;
        for (int y = y0; y <= y1; y++) begin
            for (int x = x0; x <= x1; x++) begin
                @(negedge clk);
                if (k % 7 == 6) begin
                    pix_in_valid = 0; pix_frame_start = 0; pix_in = 24'h5A5A5A;
                    @(negedge clk);
                end
                pix_in_valid = 1; pix_frame_start = first; first = 0;
                pix_x = x[11:0]; pix_y = y[11:0]; pix_in = {x[11:0], y[11:0]};
                k++;
            end
        end
        @(negedge clk);
        pix_in_valid = 0; pix_frame_start = 0;
    endtask

    task automatic reset_check(input string what, input logic [24:0] got);
        checks++;
        if (got !== 25'd0) begin
            fails++;
            $display("FAIL R1 %s got %07h exp 0000000", what, got);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs held at zero in reset
        reset_check("reset outputs", {pix_out_valid, pix_out});
        pix_in_valid = 1; pix_in = 24'hFFFFFF;
        @(negedge clk);
        reset_check("reset with input active", {pix_out_valid, pix_out});
        pix_in_valid = 0; pix_in = '0;
        rst_n = 1;

        // R5: image layout, including writes to unused offsets
        phase = "R5";
        for (int r = 0; r < 16; r++) begin
            wr(r*16 + 0, ((r*37) ^ 8'h5C) & 255);
            wr(r*16 + 1, (r*91 + 3) & 255);
            wr(r*16 + 8, 8'hF0 ^ r);
            wr(r*16 + 9, (r*17) ^ 8'h33);
            wr(r*16 + 2, 255);
            wr(r*16 + 12, 255);
        end
        area(0, 39, 0, 29, 1);  // still disabled: all pass through

        // R1: default colours visible once enabled
        phase = "R1";
        wr(9'h100, 1); wr(9'h101, 10); wr(9'h102, 5);
        area(0, 39, 0, 29, 1);

        // R7: colour registers and an ignored register index
        phase = "R7";
        wr(9'h103, 24'h123456); wr(9'h104, 24'hABCDEF); wr(9'h105, 24'h000777);
        area(0, 39, 0, 29, 1);

        // R8: position held until the next frame start
        phase = "R8";
        wr(9'h101, 30); wr(9'h102, 20);
        area(0, 49, 0, 39, 0);
        area(0, 49, 0, 39, 1);

        // R9: writes interleaved with a running frame
        phase = "R9";
        fork
            area(25, 50, 15, 40, 1);
            begin
                repeat (200) @(negedge clk);
                wr(9'h100, 0);
                repeat (150) @(negedge clk);
                wr(9'h100, 1);
                for (int r = 0; r < 16; r++) wr(r*16 + 8, 8'hFF);
                wr(9'h103, 24'h00FF00);
            end
        join

        // R10: no wrap at the top of the coordinate range
        phase = "R10";
        wr(9'h101, 4090); wr(9'h102, 100);
        area(4084, 4095, 98, 118, 1);
        area(0, 12, 98, 118, 0);

        // R4: window edges at the origin
        phase = "R4";
        wr(9'h101, 0); wr(9'h102, 0);
        area(0, 20, 0, 20, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule